// File: doc/BRIEF.md
# Multi-Channel Interrupt Latency Meter

This block times how long each of up to 32 interrupt request lines stays pending, counting clock cycles with one counter per configured line. Each request input is first brought into the clock domain through two flip-flops, then edge-detected. A channel starts counting on the rising edge of its request. In level mode it stops when the request falls. In pulse mode it stops when software writes a 1 to that channel's bit in the stop register. The finished count is latched into the channel's result register, and a per-channel valid flag is raised.

Software reaches the block through a small word-addressed register slave with a one-cycle read latency. Besides the result words, the map holds a control word, a constant clock-frequency word, the stop register and the valid mask. Software uses the frequency word to turn cycle counts into time. The control word reports the build configuration. A global enable bit in the control word arms the block.

Top module: `irq_latency_meter`

## Requirements
- R1: After reset the global enable (control bit 0) is 0, the valid mask is 0 and the read data output is 0.
- R2: A read presented with busRead high returns its data on busRdData one clock later; in any cycle after a clock with busRead low, busRdData is 0.
- R3: Offset 0x20 reads {VERSION[23:0] in bits 31:8, channel count in bits 7:2, mode in bit 1 (1 = pulse, 0 = level), enable in bit 0}; a write changes only bit 0.
- R4: Offset 0x21 reads the CLK_HZ parameter, e.g. 0x02FAF080 for 50 MHz, and writes to it are ignored.
- R5: In level mode, the result at offset ch (0x00 + ch) equals the number of clock samples for which irqIn[ch] was high.
- R6: In pulse mode, a channel starts at its synchronized rising edge, and a write of 1 to bit ch of offset 0x22 stops it. The result equals the number of clocks from the start edge to the write edge.
- R7: Completing a measurement sets bit ch of offset 0x23. A read of result offset ch clears that bit.
- R8: Offset 0x22 reads the mask of channels currently counting. In level mode, writes to it have no effect.
- R9: Result offsets at or above the channel count, and all offsets above 0x23, read as 0.
- R10: A counter saturates at its all-ones value (CNT_W bits) instead of wrapping.
- R11: While enable is 0, no channel starts, any running count is abandoned without setting valid, and results latched earlier are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_CH | Asynchronous interrupt request lines |
| busAddr | input | 6 | Word address |
| busWrite | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRead | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid one clock after busRead |

## Verification
The bench drives a request for an exact number of clocks and expects that count back, with no off-by-one. A design that counted the synchronizer delay, or missed the first or last cycle, would return one more or one less than expected. In pulse mode the stop write is placed a known number of clocks after the pulse, which catches a design that stops on the falling edge or ignores the stop register. The bench also checks that a level-mode stop write leaves the running mask alone. A narrow-counter instance is held well past its range to catch a counter that wraps. Other checks look for a design that returns stale or aliased data from unconfigured slots, lets software overwrite the read-only control fields, or keeps counting or raises valid after the enable is cleared.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int MAX_CH = 32;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_FREQ  = 6'h21;
  localparam logic [ADDR_W-1:0] OFF_STOP  = 6'h22;
  localparam logic [ADDR_W-1:0] OFF_VALID = 6'h23;

  typedef struct packed {
    logic              enable;
    logic [MAX_CH-1:0] stopHit;
    logic [MAX_CH-1:0] readClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/ilc_channel.sv
module ilc_channel #(
  parameter int CNT_W      = 32,
  parameter bit PULSE_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             riseEv,
  input  logic             fallEv,
  input  logic             stopReq,
  input  logic             readClr,
  output logic             running,
  output logic             valid,
  output logic [CNT_W-1:0] latency
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;
  logic             stopEv;
  logic             done;

  assign stopEv = PULSE_MODE ? stopReq : fallEv;
  assign done   = enable && running && stopEv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      count   <= '0;
      latency <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      count   <= '0;
    end else if (!running) begin
      if (riseEv) begin
        running <= 1'b1;
        count   <= CNT_W'(1);
      end
    end else if (stopEv) begin
      running <= 1'b0;
      latency <= count;
      count   <= '0;
    end else if (count != CNT_MAX) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        valid <= 1'b0;
    else if (done)    valid <= 1'b1;
    else if (readClr) valid <= 1'b0;
  end
endmodule

// File: rtl/ilc_datapath.sv
module ilc_datapath
  import ilc_pkg::*;
#(
  parameter int NUM_CH     = 5,
  parameter int CNT_W      = 32,
  parameter bit PULSE_MODE = 1'b0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            irqIn,
  input  ctrlStrobes_t                 strobes,
  output logic [NUM_CH-1:0]            runMask,
  output logic [NUM_CH-1:0]            validMask,
  output logic [NUM_CH-1:0][CNT_W-1:0] latency
);
  logic [NUM_CH-1:0] syncA, syncB, irqPrev;
  logic [NUM_CH-1:0] riseVec, fallVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      irqPrev <= '0;
    end else begin
      syncA   <= irqIn;
      syncB   <= syncA;
      irqPrev <= syncB;
    end
  end

  assign riseVec = syncB & ~irqPrev;
  assign fallVec = ~syncB & irqPrev;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    ilc_channel #(
      .CNT_W     (CNT_W),
      .PULSE_MODE(PULSE_MODE)
    ) uChan (
      .clk    (clk),
      .rstN   (rstN),
      .enable (strobes.enable),
      .riseEv (riseVec[ch]),
      .fallEv (fallVec[ch]),
      .stopReq(strobes.stopHit[ch]),
      .readClr(strobes.readClr[ch]),
      .running(runMask[ch]),
      .valid  (validMask[ch]),
      .latency(latency[ch])
    );
  end
endmodule

// File: rtl/ilc_control.sv
module ilc_control
  import ilc_pkg::*;
#(
  parameter int          NUM_CH     = 5,
  parameter int          CNT_W      = 32,
  parameter bit          PULSE_MODE = 1'b0,
  parameter logic [31:0] CLK_HZ     = 32'd50_000_000,
  parameter logic [23:0] VERSION    = 24'h000100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWrite,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic                         busRead,
  output logic [DATA_W-1:0]            busRdData,
  input  logic [NUM_CH-1:0]            runMask,
  input  logic [NUM_CH-1:0]            validMask,
  input  logic [NUM_CH-1:0][CNT_W-1:0] latency,
  output ctrlStrobes_t                 strobes,
  output logic                         globalEn
);
  localparam logic [5:0] CH_FIELD = 6'(NUM_CH);

  logic [DATA_W-1:0] rdMux;
  logic [MAX_CH-1:0] clrVec;

  always_ff @(posedge clk) begin
    if (!rstN) globalEn <= 1'b0;
    else if (busWrite && busAddr == OFF_CTRL) globalEn <= busWrData[0];
  end

  always_comb begin
    clrVec = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (busRead && int'(busAddr) == ch) clrVec[ch] = 1'b1;
  end

  always_comb begin
    strobes.enable  = globalEn;
    strobes.stopHit = (busWrite && busAddr == OFF_STOP) ? MAX_CH'(busWrData) : '0;
    strobes.readClr = clrVec;
  end

  always_comb begin
    rdMux = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (int'(busAddr) == ch) rdMux = DATA_W'(latency[ch]);
    case (busAddr)
      OFF_CTRL:  rdMux = {VERSION, CH_FIELD, PULSE_MODE, globalEn};
      OFF_FREQ:  rdMux = CLK_HZ;
      OFF_STOP:  rdMux = DATA_W'(runMask);
      OFF_VALID: rdMux = DATA_W'(validMask);
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busRdData <= '0;
    else if (busRead) busRdData <= rdMux;
    else              busRdData <= '0;
  end
endmodule

// File: rtl/irq_latency_meter.sv
module irq_latency_meter
  import ilc_pkg::*;
#(
  parameter int          NUM_CH     = 5,
  parameter int          CNT_W      = 32,
  parameter bit          PULSE_MODE = 1'b0,
  parameter logic [31:0] CLK_HZ     = 32'd50_000_000,
  parameter logic [23:0] VERSION    = 24'h000100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqIn,
  input  logic [5:0]        busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWrData,
  input  logic              busRead,
  output logic [31:0]       busRdData
);
  ctrlStrobes_t                 strobes;
  logic                         globalEn;
  logic [NUM_CH-1:0]            runMask;
  logic [NUM_CH-1:0]            validMask;
  logic [NUM_CH-1:0][CNT_W-1:0] latency;

  ilc_control #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PULSE_MODE(PULSE_MODE),
    .CLK_HZ(CLK_HZ), .VERSION(VERSION)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWrData(busWrData), .busRead(busRead), .busRdData(busRdData),
    .runMask(runMask), .validMask(validMask), .latency(latency),
    .strobes(strobes), .globalEn(globalEn)
  );

  ilc_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PULSE_MODE(PULSE_MODE)
  ) uData (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobes(strobes),
    .runMask(runMask), .validMask(validMask), .latency(latency)
  );
endmodule

// File: rtl/ilc_checker.sv
module ilc_checker #(
  parameter int          NUM_CH     = 5,
  parameter bit          PULSE_MODE = 1'b0,
  parameter logic [31:0] CLK_HZ     = 32'd50_000_000,
  parameter logic [23:0] VERSION    = 24'h000100
) (
  input logic              clk,
  input logic              rstN,
  input logic [5:0]        busAddr,
  input logic              busRead,
  input logic [31:0]       busRdData,
  input logic              globalEn,
  input logic [NUM_CH-1:0] runMask
);
  localparam logic [5:0] CH_FIELD = 6'(NUM_CH);

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |=> busRdData == 32'd0); // R2

  AST_CTRL_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 6'h20) |=> busRdData[31:1] == {VERSION, CH_FIELD, PULSE_MODE}); // R3

  AST_FREQ_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 6'h21) |=> busRdData == CLK_HZ); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr > 6'h23) |=> busRdData == 32'd0); // R9

  AST_HALT_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> runMask == '0); // R11
endmodule

bind irq_latency_meter ilc_checker #(
  .NUM_CH(NUM_CH), .PULSE_MODE(PULSE_MODE), .CLK_HZ(CLK_HZ), .VERSION(VERSION)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
  .busRdData(busRdData), .globalEn(globalEn), .runMask(runMask)
);

// File: tb/tb_irq_latency_meter.sv
`timescale 1ns/1ps
module tb_irq_latency_meter;
  localparam logic [23:0] VER = 24'h000100;
  localparam logic [31:0] HZ  = 32'h02FAF080;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  irq = '0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdL, rdP, rdS;
  logic [31:0] vL, vP, vS;
  int          total = 0, fails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_latency_meter #(.NUM_CH(5), .CNT_W(32), .PULSE_MODE(1'b0), .CLK_HZ(HZ), .VERSION(VER)) dut (
    .clk(clk), .rstN(rstN), .irqIn(irq), .busAddr(addr), .busWrite(wr),
    .busWrData(wdata), .busRead(rd), .busRdData(rdL));
  irq_latency_meter #(.NUM_CH(5), .CNT_W(32), .PULSE_MODE(1'b1), .CLK_HZ(HZ), .VERSION(VER)) dutP (
    .clk(clk), .rstN(rstN), .irqIn(irq), .busAddr(addr), .busWrite(wr),
    .busWrData(wdata), .busRead(rd), .busRdData(rdP));
  irq_latency_meter #(.NUM_CH(2), .CNT_W(4), .PULSE_MODE(1'b0), .CLK_HZ(HZ), .VERSION(VER)) dutS (
    .clk(clk), .rstN(rstN), .irqIn(irq[1:0]), .busAddr(addr), .busWrite(wr),
    .busWrData(wdata), .busRead(rd), .busRdData(rdS));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [5:0] a);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    vL = rdL; vP = rdP; vS = rdS;
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic holdIrq(input int ch, input int cycles);
    @(negedge clk); irq[ch] = 1'b1;
    repeat (cycles) @(negedge clk);
    irq[ch] = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rdData after reset", rdL, 32'd0);
    readReg(6'h20);
    check("R1 enable clear after reset", vL, {VER, 6'd5, 1'b0, 1'b0});
    readReg(6'h23);
    check("R1 valid mask after reset", vL, 32'd0);
  endtask

  task automatic testRegs();
    readReg(6'h21);
    check("R4 frequency word", vL, 32'h02FAF080);
    writeReg(6'h21, 32'h0);
    readReg(6'h21);
    check("R4 frequency ignores write", vL, 32'h02FAF080);
    writeReg(6'h20, 32'hFFFF_FFFF);
    readReg(6'h20);
    check("R3 ctrl level", vL, {VER, 6'd5, 1'b0, 1'b1});
    check("R3 ctrl pulse", vP, {VER, 6'd5, 1'b1, 1'b1});
    check("R3 ctrl two-channel", vS, {VER, 6'd2, 1'b0, 1'b1});
    @(negedge clk);
    check("R2 idle read data zero", rdL, 32'd0);
  endtask

  task automatic testLevel();
    holdIrq(0, 7);
    holdIrq(2, 12);
    repeat (5) @(negedge clk);
    readReg(6'h23);
    check("R7 valid bits after level runs", vL, 32'h5);
    readReg(6'h00);
    check("R5 level latency ch0", vL, 32'd7);
    readReg(6'h23);
    check("R7 read clears ch0 valid", vL, 32'h4);
    readReg(6'h02);
    check("R5 level latency ch2", vL, 32'd12);
  endtask

  task automatic testLevelIgnoresStop();
    @(negedge clk); irq[1] = 1'b1;
    repeat (6) @(negedge clk);
    writeReg(6'h22, 32'h2);
    readReg(6'h22);
    check("R8 level run mask kept after stop write", vL, 32'h2);
    irq[1] = 1'b0;
    repeat (5) @(negedge clk);
    readReg(6'h22);
    check("R8 run mask clear after fall", vL, 32'h0);
    writeReg(6'h22, 32'h1F);
  endtask

  task automatic testPulse();
    @(negedge clk); irq[3] = 1'b1;
    @(negedge clk); irq[3] = 1'b0;
    repeat (9) @(negedge clk);
    writeReg(6'h22, 32'h8);
    readReg(6'h23);
    check("R7 pulse valid bit3", vP & 32'h8, 32'h8);
    readReg(6'h03);
    check("R6 pulse latency ch3", vP, 32'd9);
  endtask

  task automatic testSaturate();
    holdIrq(1, 20);
    repeat (5) @(negedge clk);
    readReg(6'h01);
    check("R10 narrow counter saturates", vS, 32'd15);
    check("R5 wide counter exact", vL, 32'd20);
  endtask

  task automatic testUnmapped();
    readReg(6'h05);
    check("R9 unconfigured slot 5", vL, 32'd0);
    readReg(6'h1F);
    check("R9 unconfigured slot 31", vL, 32'd0);
    readReg(6'h30);
    check("R9 unmapped offset", vL, 32'd0);
    readReg(6'h02);
    check("R9 two-channel slot 2", vS, 32'd0);
  endtask

  task automatic testDisable();
    writeReg(6'h20, 32'h0);
    @(negedge clk); irq[4] = 1'b1;
    @(negedge clk); irq[4] = 1'b0;
    repeat (4) @(negedge clk);
    readReg(6'h22);
    check("R11 no start while disabled", vP, 32'd0);
    writeReg(6'h20, 32'h1);
    @(negedge clk); irq[4] = 1'b1;
    @(negedge clk); irq[4] = 1'b0;
    repeat (4) @(negedge clk);
    readReg(6'h22);
    check("R11 pulse run started when enabled", vP, 32'h10);
    writeReg(6'h20, 32'h0);
    repeat (2) @(negedge clk);
    readReg(6'h22);
    check("R11 disable abandons run", vP, 32'd0);
    readReg(6'h23);
    check("R11 abandoned run sets no valid", vP & 32'h10, 32'd0);
    readReg(6'h03);
    check("R11 earlier result kept", vP, 32'd9);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testLevel();
    testLevelIgnoresStop();
    testPulse();
    testSaturate();
    testUnmapped();
    testDisable();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule